// File: doc/BRIEF.md
# Paged Address Translator with Access Checking

This block sits between a CPU and its main memory. Each access strobe presents a logical address, a read/write flag and a supervisor flag. Addresses inside the low translated region are split into a page index and a page offset. The index selects one word of an on-chip map store, and that word supplies the physical page number. Addresses above the region leave the block unchanged.

In the same cycle the access is classified, either as allowed or as one of four faults. Supervisor accesses are always allowed. User accesses pass through a fixed priority chain. When an access succeeds on a page that is marked present, the block sets the page's referenced and dirty flags in the map word. Software maintains the map words through a second, independent port that has byte enables.

The result of each strobe appears one clock after it: a registered valid flag, the physical address and a 3-bit fault code. The bus-error path and the memory itself are outside this block.

Top module: `pmmu_xlate`

## Requirements
- R1: After reset, `rsp_valid` is low and every map word reads back as 0x0000.
- R2: A strobe with a logical address below 0x400000 gives `rsp_valid` high on the following cycle. In that cycle `rsp_paddr` = {2'b00, map[addr[21:12]][9:0], addr[11:0]}.
- R3: A strobe with a logical address at or above 0x400000 returns that address unchanged on `rsp_paddr`.
- R4: A supervisor-mode strobe (`acc_super`=1) always returns fault code 0, including on absent pages and on the kernel window.
- R5: User-mode fault codes are checked in this priority order:
  - 4 when the address is at or above 0x400000.
  - 1 when map bits 14:13 are both zero (page absent).
  - 3 when logical bits 22:19 are all zero (kernel window).
  - 2 when the access is a write and map bit 15 is clear.
  - 0 otherwise.
- R6: A user read of a present page outside the kernel window is allowed even when map bit 15 is clear.
- R7: An allowed, translated access to a map word whose bits 14:13 are nonzero updates that word one clock after the strobe. A write sets bits 14 and 13. A read sets bit 14. A word whose bits 14:13 are zero is left unchanged.
- R8: A faulting access leaves its map word unchanged.
- R9: On the map port, `cfg_be[1]` writes bits 15:8 and `cfg_be[0]` writes bits 7:0; a byte whose enable is low keeps its old value. A read returns the word on `cfg_rdata` one clock later.
- R10: If a map-port write and a status update target the same word in the same cycle, the word takes the map-port write and the status update is dropped. The access response still uses the word as it was before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access strobe, one per cycle |
| acc_addr | input | 24 | Logical address |
| acc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| acc_super | input | 1 | 1 = supervisor mode |
| rsp_valid | output | 1 | Result valid, one clock after the strobe |
| rsp_paddr | output | 24 | Physical address |
| rsp_fault | output | 3 | Fault code (0 allowed, 1 absent, 2 not writable, 3 kernel, 4 non-memory) |
| cfg_en | input | 1 | Map port request |
| cfg_we | input | 1 | Map port write (1) or read (0) |
| cfg_idx | input | 10 | Map word index |
| cfg_be | input | 2 | Byte enables for a map write |
| cfg_wdata | input | 16 | Map write data |
| cfg_rdata | output | 16 | Map read data, one clock after the request |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 10-bit page index, a 12-bit offset and the kernel window on bits 22:19. With these values the full 1024-word map and the 0x400000 translation boundary are reachable, as is the kernel window boundary at 0x080000. This lets the bench place pages on both sides of every priority step. It can then check that each fault code wins over the ones below it, that the status flags change only on allowed accesses, and that a same-cycle map write overrides a status update.

// File: rtl/pmmu_pkg.sv
package pmmu_pkg;

    localparam int ADDR_W  = 24;
    localparam int IDX_W   = 10;
    localparam int OFS_W   = 12;
    localparam int PPN_W   = 10;
    localparam int ENTRY_W = 16;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_RDONLY = 3'd2,
        FLT_KERNEL = 3'd3,
        FLT_NONMEM = 3'd4
    } fault_e;

    // Map word layout; the bit positions are part of the block's behaviour.
    typedef struct packed {
        logic             wr_ok;   // 15
        logic [1:0]       stat;    // 14:13, stat[1] = referenced
        logic [2:0]       spare;   // 12:10
        logic [PPN_W-1:0] ppn;     // 9:0
    } map_entry_t;

    typedef struct packed {
        logic [ADDR_W-1:0] paddr;
        fault_e            fault;
    } xlate_rsp_t;

    function automatic logic [ENTRY_W-1:0] merge_bytes(
        input logic [ENTRY_W-1:0] old_w,
        input logic [ENTRY_W-1:0] new_w,
        input logic [1:0]         be
    );
        logic [ENTRY_W-1:0] r;
        r = old_w;
        if (be[1]) r[15:8] = new_w[15:8];
        if (be[0]) r[7:0]  = new_w[7:0];
        return r;
    endfunction

    function automatic logic [1:0] touch_bits(input logic is_write);
        return is_write ? 2'b11 : 2'b10;
    endfunction

endpackage

// File: rtl/pmmu_check.sv
module pmmu_check
    import pmmu_pkg::*;
#(
    parameter int A_W     = ADDR_W,
    parameter int X_IDX_W = IDX_W,
    parameter int X_OFS_W = OFS_W,
    parameter int KRN_LSB = 19,
    parameter int KRN_MSB = 22
) (
    input  logic [A_W-1:0]     addr,
    input  logic               is_wr,
    input  logic               is_sup,
    input  map_entry_t         ent,
    output logic [X_IDX_W-1:0] idx,
    output logic [A_W-1:0]     paddr,
    output fault_e             fault,
    output logic               upd_en,
    output logic [1:0]         upd_bits
);
    localparam int XLATE_W = X_IDX_W + X_OFS_W;

    logic in_map;
    logic present;
    logic krn_hit;

    assign in_map  = (addr >> XLATE_W) == '0;
    assign idx     = addr[XLATE_W-1:X_OFS_W];
    assign present = ent.stat != 2'b00;
    assign krn_hit = addr[KRN_MSB:KRN_LSB] == '0;

    always_comb begin
        paddr = addr;
        if (in_map) begin
            paddr = '0;
            paddr[X_OFS_W-1:0]       = addr[X_OFS_W-1:0];
            paddr[XLATE_W-1:X_OFS_W] = ent.ppn[X_IDX_W-1:0];
        end
    end

    always_comb begin
        if (is_sup)           fault = FLT_NONE;
        else if (!in_map)     fault = FLT_NONMEM;
        else if (!present)    fault = FLT_ABSENT;
        else if (krn_hit)     fault = FLT_KERNEL;
        else if (is_wr && !ent.wr_ok) fault = FLT_RDONLY;
        else                  fault = FLT_NONE;
    end

    assign upd_en   = in_map && present && (fault == FLT_NONE);
    assign upd_bits = touch_bits(is_wr);

endmodule

// File: rtl/pmmu_map_ram.sv
module pmmu_map_ram
    import pmmu_pkg::*;
#(
    parameter int M_IDX_W = IDX_W,
    parameter int DEPTH   = 1 << M_IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [M_IDX_W-1:0] lk_idx,
    output map_entry_t         lk_entry,
    input  logic               upd_en,
    input  logic [M_IDX_W-1:0] upd_idx,
    input  logic [1:0]         upd_bits,
    input  logic               cfg_en,
    input  logic               cfg_we,
    input  logic [M_IDX_W-1:0] cfg_idx,
    input  logic [1:0]         cfg_be,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    output logic [ENTRY_W-1:0] cfg_rdata
);
    map_entry_t store [DEPTH];

    logic cfg_wr;
    logic upd_ok;

    assign cfg_wr   = cfg_en && cfg_we;
    // Map-port write takes the word when both target it.
    assign upd_ok   = upd_en && !(cfg_wr && (cfg_idx == upd_idx));
    assign lk_entry = store[lk_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
            cfg_rdata <= '0;
        end else begin
            if (upd_ok)
                store[upd_idx].stat <= store[upd_idx].stat | upd_bits;
            if (cfg_wr)
                store[cfg_idx] <= map_entry_t'(merge_bytes(store[cfg_idx], cfg_wdata, cfg_be));
            if (cfg_en && !cfg_we)
                cfg_rdata <= store[cfg_idx];
        end
    end

endmodule

// File: rtl/pmmu_xlate.sv
module pmmu_xlate
    import pmmu_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_IDX_W  = IDX_W,
    parameter int P_OFS_W  = OFS_W,
    parameter int KRN_LSB  = 19,
    parameter int KRN_MSB  = 22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_req,
    input  logic [P_ADDR_W-1:0] acc_addr,
    input  logic                acc_wr,
    input  logic                acc_super,
    output logic                rsp_valid,
    output logic [P_ADDR_W-1:0] rsp_paddr,
    output logic [2:0]          rsp_fault,
    input  logic                cfg_en,
    input  logic                cfg_we,
    input  logic [P_IDX_W-1:0]  cfg_idx,
    input  logic [1:0]          cfg_be,
    input  logic [15:0]         cfg_wdata,
    output logic [15:0]         cfg_rdata
);
    logic [P_IDX_W-1:0]  page_idx;
    map_entry_t          page_ent;
    logic [P_ADDR_W-1:0] xl_paddr;
    fault_e              xl_fault;
    logic                xl_upd;
    logic [1:0]          xl_bits;
    xlate_rsp_t          rsp_q;
    logic                valid_q;

    pmmu_check #(
        .A_W(P_ADDR_W), .X_IDX_W(P_IDX_W), .X_OFS_W(P_OFS_W),
        .KRN_LSB(KRN_LSB), .KRN_MSB(KRN_MSB)
    ) u_check (
        .addr(acc_addr), .is_wr(acc_wr), .is_sup(acc_super), .ent(page_ent),
        .idx(page_idx), .paddr(xl_paddr), .fault(xl_fault),
        .upd_en(xl_upd), .upd_bits(xl_bits)
    );

    pmmu_map_ram #(.M_IDX_W(P_IDX_W)) u_map (
        .clk(clk), .rst(rst),
        .lk_idx(page_idx), .lk_entry(page_ent),
        .upd_en(acc_req && xl_upd), .upd_idx(page_idx), .upd_bits(xl_bits),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q <= acc_req;
            if (acc_req) begin
                rsp_q.paddr <= xl_paddr;
                rsp_q.fault <= xl_fault;
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;

endmodule

// File: rtl/pmmu_xlate_chk.sv
module pmmu_xlate_chk #(
    parameter int C_ADDR_W = 24,
    parameter int C_XW     = 22
) (
    input logic                clk,
    input logic                rst,
    input logic                acc_req,
    input logic [C_ADDR_W-1:0] acc_addr,
    input logic                acc_wr,
    input logic                acc_super,
    input logic                rsp_valid,
    input logic [C_ADDR_W-1:0] rsp_paddr,
    input logic [2:0]          rsp_fault
);
    logic high_addr;
    assign high_addr = (acc_addr >> C_XW) != '0;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !rsp_valid); // R1
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> rsp_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !acc_req |=> !rsp_valid); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> rsp_paddr[11:0] == $past(acc_addr[11:0])); // R2
    AST_HIGH_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        acc_req && high_addr |=> rsp_paddr == $past(acc_addr)); // R3
    AST_SUPER_ALLOWED: assert property (@(posedge clk) disable iff (rst)
        acc_req && acc_super |=> rsp_fault == 3'd0); // R4
    AST_USER_NONMEM: assert property (@(posedge clk) disable iff (rst)
        acc_req && !acc_super && high_addr |=> rsp_fault == 3'd4); // R5
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_fault <= 3'd4); // R5
    AST_READ_NOT_RDONLY: assert property (@(posedge clk) disable iff (rst)
        acc_req && !acc_wr |=> rsp_fault != 3'd2); // R6
endmodule

bind pmmu_xlate pmmu_xlate_chk #(
    .C_ADDR_W(P_ADDR_W), .C_XW(P_IDX_W + P_OFS_W)
) u_chk (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_super(acc_super), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/pmmu_xlate_tb_top.sv
`timescale 1ns/1ps
module pmmu_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_req = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        acc_super = 1'b0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [2:0]  rsp_fault;
    logic        cfg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_idx = '0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pmmu_xlate dut_i (
        .clk(clk), .rst(rst), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_wr(acc_wr), .acc_super(acc_super), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .cfg_en(cfg_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    typedef struct {
        logic [23:0] paddr;
        logic [2:0]  fault;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] model [1024];

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                          input logic [1:0] be);
        logic [15:0] r;
        r = o;
        if (be[1]) r[15:8] = n[15:8];
        if (be[0]) r[7:0] = n[7:0];
        return r;
    endfunction

    function automatic exp_t predict(input logic [23:0] a, input logic w, input logic s,
                                     input string tag);
        exp_t        e;
        logic [15:0] m;
        m = model[a[21:12]];
        e.tag = tag;
        e.paddr = (a < 24'h400000) ? {2'b00, m[9:0], a[11:0]} : a;
        if (s)                   e.fault = 3'd0;
        else if (a >= 24'h400000) e.fault = 3'd4;
        else if (m[14:13] == 0)  e.fault = 3'd1;
        else if (a[22:19] == 0)  e.fault = 3'd3;
        else if (w && !m[15])    e.fault = 3'd2;
        else                     e.fault = 3'd0;
        return e;
    endfunction

    function automatic void model_touch(input logic [23:0] a, input logic w, input exp_t e);
        if (a < 24'h400000 && e.fault == 3'd0 && model[a[21:12]][14:13] != 2'b00)
            model[a[21:12]] = model[a[21:12]] | (w ? 16'h6000 : 16'h4000);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Driver: presents one access for one cycle and queues its expectation.
    task automatic issue(input logic [23:0] a, input logic w, input logic s, input string tag);
        exp_t e;
        e = predict(a, w, s, tag);
        model_touch(a, w, e);
        sb_q.push_back(e);
        acc_req = 1'b1; acc_addr = a; acc_wr = w; acc_super = s;
        @(negedge clk);
    endtask

    task automatic idle();
        acc_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic access(input logic [23:0] a, input logic w, input logic s, input string tag);
        issue(a, w, s, tag);
        idle();
    endtask

    task automatic map_write(input logic [9:0] i, input logic [1:0] be, input logic [15:0] d);
        model[i] = merge(model[i], d, be);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_idx = i; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic map_check(input logic [9:0] i, input string req);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_idx = i;
        @(negedge clk);
        cfg_en = 1'b0;
        check(cfg_rdata == model[i], req, $sformatf("map word %0h", i), cfg_rdata, model[i]);
    endtask

    // Monitor: compares each response against the head of the queue.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_paddr == e.paddr, e.tag, "paddr", rsp_paddr, e.paddr);
                check(rsp_fault == e.fault, e.tag, "fault", rsp_fault, e.fault);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        map_check(10'h000, "R1");
        map_check(10'h3FF, "R1");
        map_check(10'h100, "R1");

        // R9: byte-enabled writes build the word in two halves
        map_write(10'h100, 2'b10, 16'hA0FF);
        map_check(10'h100, "R9");
        map_write(10'h100, 2'b01, 16'h3355);
        map_check(10'h100, "R9");
        map_write(10'h101, 2'b11, 16'h20AA);
        map_write(10'h104, 2'b11, 16'h2033);
        map_write(10'h010, 2'b11, 16'hA3FF);
        map_write(10'h012, 2'b11, 16'h2012);
        map_write(10'h3FF, 2'b11, 16'hE001);
        map_write(10'h105, 2'b11, 16'hA005);

        // R2 / R4 / R7: supervisor read translates and marks referenced
        access(24'h100ABC, 1'b0, 1'b1, "R4");
        map_check(10'h100, "R7");
        // R2 / R7: user write allowed, marks dirty
        access(24'h100004, 1'b1, 1'b0, "R2");
        map_check(10'h100, "R7");
        // R6: user read of a non-writable present page
        access(24'h101010, 1'b0, 1'b0, "R6");
        map_check(10'h101, "R7");
        // R5 / R8: write to non-writable page faults, word unchanged
        access(24'h104020, 1'b1, 1'b0, "R5");
        map_check(10'h104, "R8");
        // R5: absent page
        access(24'h102000, 1'b0, 1'b0, "R5");
        map_check(10'h102, "R8");
        // R5: absent wins over kernel window
        access(24'h011000, 1'b0, 1'b0, "R5");
        // R5 / R8: kernel window fault, word unchanged
        access(24'h010000, 1'b0, 1'b0, "R5");
        map_check(10'h010, "R8");
        // R5: kernel wins over write-enable
        access(24'h012004, 1'b1, 1'b0, "R5");
        // R3 / R5: user non-memory, passthrough
        access(24'h400000, 1'b0, 1'b0, "R3");
        access(24'hE43000, 1'b1, 1'b1, "R3");
        // R4 / R7: supervisor to absent page allowed, no status change
        access(24'h102FFF, 1'b0, 1'b1, "R4");
        map_check(10'h102, "R7");
        // R4 / R7: supervisor to kernel page allowed and touched
        access(24'h010123, 1'b1, 1'b1, "R4");
        map_check(10'h010, "R7");
        // R2: back-to-back strobes, top page
        issue(24'h3FF800, 1'b0, 1'b0, "R2");
        issue(24'h3FF804, 1'b1, 1'b0, "R2");
        issue(24'h101FFF, 1'b1, 1'b0, "R5");
        idle();
        map_check(10'h3FF, "R7");

        // R10: map write and status update hit the same word together
        begin
            exp_t e;
            e = predict(24'h105000, 1'b1, 1'b0, "R10");
            sb_q.push_back(e);
            model[10'h105] = merge(model[10'h105], 16'h8077, 2'b11);
            acc_req = 1'b1; acc_addr = 24'h105000; acc_wr = 1'b1; acc_super = 1'b0;
            cfg_en = 1'b1; cfg_we = 1'b1; cfg_idx = 10'h105; cfg_be = 2'b11;
            cfg_wdata = 16'h8077;
            @(negedge clk);
            acc_req = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0;
            @(negedge clk);
        end
        map_check(10'h105, "R10");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2", "responses outstanding", sb_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule